// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks lock reservations for load-linked/store-conditional atomics at cache-line granularity. It watches a stream of request completions. Each completion carries a line address, the identifier of the requester and a two-bit request kind. A load-linked completion places a reservation on its line and tags it with the requester. A later store-conditional from the same requester succeeds only while that reservation is still intact. The block returns a registered pass/fail bit for every completion, together with a flag that marks the kinds that must be treated as atomic downstream, so that the coherence logic does not apply migratory-sharing shortcuts to them.

Reservations are lost in four ways. A store-conditional to the line clears the lock whether or not it succeeds. An ordinary write by the owning requester clears it. An invalidation clears it when the line's pending write is a store-conditional. A newer load-linked can also take the slot when every slot is busy. The monitor keeps a small fully associative set of slots. It holds at most one slot per line and picks replacement victims with a rotating pointer.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked completion (kind 2'b01) always reports success 1. After it, the line holds a valid reservation owned by the requester's identifier.
- R2: A store-conditional completion (kind 2'b10) reports success 1 when a valid reservation exists on its line with the same requester identifier, and 0 otherwise.
- R3: Every store-conditional completion removes the reservation on its line, whether it succeeded or failed and whichever requester owned it.
- R4: A write completion (kind 2'b11) removes the reservation on its line only when the reservation is owned by the same requester. A write by another requester, and any read completion (kind 2'b00), leave every reservation unchanged.
- R5: A load-linked on a line that is already reserved reuses that slot and replaces its owner. No line ever occupies two slots.
- R6: A load-linked on an unreserved line takes the lowest-numbered free slot. When all slots are valid, it replaces the slot under a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such replacement only.
- R7: An invalidation strobe with the store-conditional-pending flag set removes the reservation on the given line. With the flag clear it has no effect. When it arrives in the same cycle as a completion, it is applied after the completion's update.
- R8: The response is valid for exactly one cycle, the cycle after the completion strobe. The atomic flag is 1 for load-linked and store-conditional and 0 for reads and writes. Read and write completions report success 1.
- R9: Reset drops every reservation, returns the rotating pointer to slot 0 and drives the response outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Completion strobe |
| cmp_kind | input | 2 | 00 read, 01 load-linked, 10 store-conditional, 11 write |
| cmp_line | input | LINE_AW | Line address of the completion |
| cmp_id | input | ID_W | Requester identifier |
| inv_valid | input | 1 | Invalidation strobe |
| inv_sc_pending | input | 1 | Pending write for the line is a store-conditional |
| inv_line | input | LINE_AW | Line address losing permission |
| rsp_valid | output | 1 | Response strobe, one cycle after the completion |
| rsp_success | output | 1 | 1 on success, 0 on a failed store-conditional |
| rsp_atomic | output | 1 | Completion was load-linked or store-conditional |

## Verification
Directed sequences separate the owner rules. They pair a load-linked with a store-conditional from the same requester and from a different one, with writes by the owner and by a stranger, and with a second load-linked that moves ownership, so that each clearing rule is seen apart from the others. A fill of more than four distinct lines shows which slot is evicted, and thereby exposes a wrong pointer start, a wrong advance or a wrong free-slot choice. Invalidations are sent with the pending flag both set and clear, and once in the same cycle as a load-linked, to fix the ordering. A long random mix on six lines and four requesters then collides lines and owners across all kinds against a reference model in the bench.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    CK_READ  = 2'b00,
    CK_LL    = 2'b01,
    CK_SC    = 2'b10,
    CK_WRITE = 2'b11
  } cmp_kind_e;
endpackage

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int LINE_AW = 26,
  parameter int ID_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set,
  input  logic               set_kill,
  input  logic               clr,
  input  logic [LINE_AW-1:0] new_line,
  input  logic [ID_W-1:0]    new_id,
  output logic               vld,
  output logic [LINE_AW-1:0] line,
  output logic [ID_W-1:0]    id
);
  // valid bit is reset; tag and owner are only meaningful while valid
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (set) begin
      vld <= !set_kill;
    end else if (clr) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set) begin
      line <= new_line;
      id   <= new_id;
    end
  end

  AST_SET_LOADS: assert property (@(posedge clk) disable iff (rst)
    (set && !set_kill) |=> (vld && line == $past(new_line) && id == $past(new_id))); // R1
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !vld); // R3
endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] slot_vld,
  input  logic                 replace,
  output logic                 all_full,
  output logic [NUM_SLOTS-1:0] pick
);
  localparam int PTR_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [PTR_W-1:0]     rr_ptr;
  logic [NUM_SLOTS-1:0] free_pick;

  assign all_full = &slot_vld;

  // lowest free slot wins
  always_comb begin
    free_pick = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        free_pick    = '0;
        free_pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (all_full) begin
      pick = '0;
      pick[rr_ptr] = 1'b1;
    end else begin
      pick = free_pick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (replace) begin
      rr_ptr <= (rr_ptr == PTR_W'(NUM_SLOTS - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_ONE_PICK: assert property (@(posedge clk) disable iff (rst)
    replace |-> ($countones(pick) == 1 && all_full)); // R6
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int NUM_SLOTS = 4,
  parameter int LINE_AW   = 26,
  parameter int ID_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmp_valid,
  input  logic [1:0]         cmp_kind,
  input  logic [LINE_AW-1:0] cmp_line,
  input  logic [ID_W-1:0]    cmp_id,
  input  logic               inv_valid,
  input  logic               inv_sc_pending,
  input  logic [LINE_AW-1:0] inv_line,
  output logic               rsp_valid,
  output logic               rsp_success,
  output logic               rsp_atomic
);
  import llsc_pkg::*;

  cmp_kind_e kind;
  logic      is_ll, is_sc, is_wr, inv_en, inv_on_new;

  assign kind       = cmp_kind_e'(cmp_kind);
  assign is_ll      = cmp_valid && (kind == CK_LL);
  assign is_sc      = cmp_valid && (kind == CK_SC);
  assign is_wr      = cmp_valid && (kind == CK_WRITE);
  assign inv_en     = inv_valid && inv_sc_pending;
  assign inv_on_new = inv_en && (inv_line == cmp_line);

  logic [NUM_SLOTS-1:0] s_vld, hit_c, own_c, hit_i, s_set, s_clr, pick;
  logic [LINE_AW-1:0]   s_line [NUM_SLOTS];
  logic [ID_W-1:0]      s_id   [NUM_SLOTS];
  logic                 hit_any, own_any, all_full, replace;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hit_c[g] = s_vld[g] && (s_line[g] == cmp_line);
    assign own_c[g] = hit_c[g] && (s_id[g] == cmp_id);
    assign hit_i[g] = s_vld[g] && (s_line[g] == inv_line);
    assign s_set[g] = is_ll && (hit_any ? hit_c[g] : pick[g]);
    assign s_clr[g] = (is_sc && hit_c[g]) || (is_wr && own_c[g]) || (inv_en && hit_i[g]);

    llsc_slot #(.LINE_AW(LINE_AW), .ID_W(ID_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .set      (s_set[g]),
      .set_kill (inv_on_new),
      .clr      (s_clr[g]),
      .new_line (cmp_line),
      .new_id   (cmp_id),
      .vld      (s_vld[g]),
      .line     (s_line[g]),
      .id       (s_id[g])
    );
  end

  assign hit_any = |hit_c;
  assign own_any = |own_c;
  assign replace = is_ll && !hit_any && all_full;

  llsc_victim #(.NUM_SLOTS(NUM_SLOTS)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .slot_vld (s_vld),
    .replace  (replace),
    .all_full (all_full),
    .pick     (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_success <= 1'b0;
      rsp_atomic  <= 1'b0;
    end else begin
      rsp_valid   <= cmp_valid;
      rsp_success <= cmp_valid && !(is_sc && !own_any);
      rsp_atomic  <= is_ll || is_sc;
    end
  end

  // checking aids: duplicate lines, and lines hit by the last invalidation
  logic               dup_line, inv_q, inv_left;
  logic [LINE_AW-1:0] inv_line_q;

  always_ff @(posedge clk) begin
    if (rst) inv_q <= 1'b0;
    else     inv_q <= inv_en;
    inv_line_q <= inv_line;
  end

  always_comb begin
    dup_line = 1'b0;
    inv_left = 1'b0;
    for (int a = 0; a < NUM_SLOTS; a++) begin
      if (s_vld[a] && s_line[a] == inv_line_q) inv_left = 1'b1;
      for (int b = a + 1; b < NUM_SLOTS; b++) begin
        if (s_vld[a] && s_vld[b] && s_line[a] == s_line[b]) dup_line = 1'b1;
      end
    end
  end

  AST_LL_REPORTS_OK: assert property (@(posedge clk) disable iff (rst)
    is_ll |=> (rsp_valid && rsp_success)); // R1
  AST_SC_NEEDS_OWNER: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !own_any) |=> (rsp_valid && !rsp_success)); // R2
  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (rst)
    !dup_line); // R5
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    inv_q |-> !inv_left); // R7
  AST_ATOMIC_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_atomic |-> rsp_valid); // R8
endmodule

// File: tb/sim_llsc_resv_monitor.sv
`timescale 1ns/1ps
module sim_llsc_resv_monitor;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_valid = 1'b0, inv_valid = 1'b0, inv_sc_pending = 1'b0;
  logic [1:0] cmp_kind = 2'b00;
  logic [AW-1:0] cmp_line = '0, inv_line = '0;
  logic [IW-1:0] cmp_id = '0;
  logic rsp_valid, rsp_success, rsp_atomic;

  always #2 clk = ~clk;

  llsc_resv_monitor #(.NUM_SLOTS(N), .LINE_AW(AW), .ID_W(IW)) u0 (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
    .cmp_line(cmp_line), .cmp_id(cmp_id), .inv_valid(inv_valid),
    .inv_sc_pending(inv_sc_pending), .inv_line(inv_line),
    .rsp_valid(rsp_valid), .rsp_success(rsp_success), .rsp_atomic(rsp_atomic)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  bit          m_v [N];
  int unsigned m_line [N];
  int unsigned m_id [N];
  int          m_rr;

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endtask

  function automatic int find_line(int unsigned ln);
    for (int i = 0; i < N; i++) if (m_v[i] && m_line[i] == ln) return i;
    return -1;
  endfunction

  function automatic bit exp_success(int k, int unsigned ln, int unsigned idv);
    int j = find_line(ln);
    if (k != 2) return 1;
    return (j >= 0) && (m_id[j] == idv);
  endfunction

  task automatic model_update(int k, int unsigned ln, int unsigned idv,
                              bit iv, bit ip, int unsigned il);
    int j = find_line(ln);
    int f = -1;
    if (k == 1) begin
      if (j >= 0) m_id[j] = idv;
      else begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) f = i;
        if (f < 0) begin f = m_rr; m_rr = (m_rr + 1) % N; end
        m_v[f] = 1; m_line[f] = ln; m_id[f] = idv;
      end
    end else if (k == 2) begin
      if (j >= 0) m_v[j] = 0;
    end else if (k == 3) begin
      if (j >= 0 && m_id[j] == idv) m_v[j] = 0;
    end
    if (iv && ip) for (int i = 0; i < N; i++) if (m_v[i] && m_line[i] == il) m_v[i] = 0;
  endtask

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the response
  task automatic op(string req, int k, int unsigned ln, int unsigned idv,
                    bit iv = 0, bit ip = 0, int unsigned il = 0);
    bit es = exp_success(k, ln, idv);
    bit ea = (k == 1) || (k == 2);
    cmp_valid = 1; cmp_kind = 2'(k); cmp_line = AW'(ln); cmp_id = IW'(idv);
    inv_valid = iv; inv_sc_pending = ip; inv_line = AW'(il);
    model_update(k, ln, idv, iv, ip, il);
    @(posedge clk); @(negedge clk);
    cmp_valid = 0; inv_valid = 0; inv_sc_pending = 0;
    check(req, "rsp_valid", rsp_valid, 1);
    check(req, "rsp_success", rsp_success, es);
    check(req, "rsp_atomic", rsp_atomic, ea);
  endtask

  task automatic idle(string req);
    @(posedge clk); @(negedge clk);
    check(req, "idle rsp_valid", rsp_valid, 0);
    check(req, "idle rsp_atomic", rsp_atomic, 0);
  endtask

  task automatic do_reset();
    rst = 1; model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    check("R9", "reset rsp_valid", rsp_valid, 0);
    check("R9", "reset rsp_success", rsp_success, 0);
    op("R9", 2, 1, 1);                     // nothing reserved after reset
    idle("R8");

    op("R1", 1, 5, 1);
    op("R2", 2, 5, 1);                     // expect 1
    op("R3", 2, 5, 1);                     // expect 0, cleared
    op("R1", 1, 6, 1);
    op("R2", 2, 6, 2);                     // wrong owner: 0
    op("R3", 2, 6, 1);                     // failed SC still cleared: 0

    op("R4", 1, 7, 1);
    op("R4", 3, 7, 2);                     // stranger write: no effect
    op("R4", 0, 7, 1);                     // read: no effect
    op("R4", 2, 7, 1);                     // expect 1
    op("R4", 1, 7, 1);
    op("R4", 3, 7, 1);                     // owner write clears
    op("R4", 2, 7, 1);                     // expect 0

    op("R5", 1, 8, 1);
    op("R5", 1, 8, 2);
    op("R5", 2, 8, 1);                     // owner moved: 0
    op("R5", 1, 8, 1);
    op("R5", 1, 8, 2);
    op("R5", 2, 8, 2);                     // expect 1

    for (int i = 0; i < 4; i++) op("R6", 1, 10 + i, 3);
    op("R6", 1, 14, 3);                    // evicts slot 0 (line 10)
    op("R6", 1, 15, 3);                    // evicts slot 1 (line 11)
    op("R6", 2, 10, 3);                    // 0
    op("R6", 2, 12, 3);                    // 1, frees slot 2
    op("R6", 1, 16, 3);                    // takes free slot 2
    op("R6", 1, 17, 3);                    // evicts slot 2 (pointer at 2)
    op("R6", 2, 13, 3);                    // 1
    op("R6", 2, 16, 3);                    // 0

    do_reset();
    op("R7", 1, 20, 3);
    op("R7", 0, 1, 0, 1, 0, 20);           // flag clear: no effect
    op("R7", 2, 20, 3);                    // 1
    op("R7", 1, 20, 3);
    op("R7", 0, 1, 0, 1, 1, 20);           // clears
    op("R7", 2, 20, 3);                    // 0
    op("R7", 1, 21, 3, 1, 1, 21);          // same cycle, inval applied after
    op("R7", 2, 21, 3);                    // 0

    op("R9", 1, 30, 1);
    do_reset();
    op("R9", 2, 30, 1);                    // 0

    void'($urandom(32'h5eed1234));
    for (int n = 0; n < 3000; n++) begin
      int k = int'($urandom_range(3, 0));
      int unsigned ln = $urandom_range(5, 0);
      int unsigned idv = $urandom_range(3, 0);
      bit iv = ($urandom_range(7, 0) == 0);
      bit ip = $urandom_range(1, 0);
      int unsigned il = $urandom_range(5, 0);
      op("R2", k, ln, idv, iv, ip, il);
      if ($urandom_range(15, 0) == 0) idle("R8");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule